// File: doc/BRIEF.md
# Extendable 8/16-bit Up-Counting Timer

This block is a free-running up-counter that raises a timeout when it wraps. It always has a low byte. A high byte can be pulled in at runtime with an enable input, and the two bytes then form one 16-bit counter. With the enable off, the high byte keeps its value and the counter wraps at 256. With the enable on, the counter wraps at 65536.

Software loads either byte through a shared data bus that has a separate write strobe for each byte. It reads each byte back on its own output.

The counter advances on instruction-rate ticks derived from the system clock. A mode input sets the rate. In two-clock mode there is one tick per clock. In four-clock mode there is one tick every second clock. On each wrap the block gives a single-cycle timeout pulse.

Top module: `ext_timer`

## Requirements
- R1: While `rst_ni` is low, `lo_o`, `hi_o` and `tmo_o` are all 0.
- R2: With `clk_mode_i` = 0 (two-clock mode), the low byte increments by one on every clock edge that has no low-byte write.
- R3: With `clk_mode_i` = 1 (four-clock mode), the low byte increments on every second edge. A low-byte write restarts this phase, so the first increment comes two edges after the write, and a loaded value L wraps after 2×(256−L) edges.
- R4: With `hi_en_i` = 0, a low value L wraps to 0 after 256−L ticks and raises a timeout. The high byte does not change unless it is written.
- R5: With `hi_en_i` = 1, every low-byte wrap adds one to the high byte. A timeout occurs only when both bytes wrap, which is 65536−(H×256+L) ticks after loading H and L.
- R6: `tmo_o` is high for exactly one cycle. That cycle directly follows the edge on which the counter wrapped, and in it `lo_o` reads 0.
- R7: A low-byte write (`lo_we_i` = 1) loads `wdata_i` into the low byte in place of the increment on that edge.
- R8: A high-byte write (`hi_we_i` = 1) loads `wdata_i` into the high byte in place of any carry on that edge.
- R9: A write that replaces the wrapping increment of a byte cancels the timeout for that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hi_en_i | input | 1 | 1: high byte extends the counter to 16 bits |
| clk_mode_i | input | 1 | 0: tick every clock; 1: tick every second clock |
| lo_we_i | input | 1 | Low-byte write strobe |
| hi_we_i | input | 1 | High-byte write strobe |
| wdata_i | input | 8 | Write data for either byte |
| lo_o | output | 8 | Low-byte read-back |
| hi_o | output | 8 | High-byte read-back |
| tmo_o | output | 1 | One-cycle timeout pulse |

## Verification
The properties assume that all inputs are known and stable at each rising clock edge. They also assume that `wdata_i` is valid whenever either strobe is high, and that mode and enable changes happen between edges rather than on them. The stimulus respects this: every input is driven only at falling edges, and the bus always carries a defined value. The per-edge step property applies only in two-clock mode. The four-clock rate is therefore checked by the bench through wrap timing after a load, because the load restarts the tick phase and makes that timing deterministic.

// File: rtl/ext_timer_pkg.sv
package ext_timer_pkg;
  typedef enum logic {
    CPI_TWO  = 1'b0,
    CPI_FOUR = 1'b1
  } cpi_mode_e;
endpackage

// File: rtl/ext_timer_tick.sv
module ext_timer_tick
  import ext_timer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  cpi_mode_e mode_i,
  input  logic      restart_i,
  output logic      tick_o
);
  logic ph_q;

  // phase toggles only in four-clock mode; a low-byte load restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ph_q <= 1'b0;
    else if (mode_i == CPI_TWO || restart_i)    ph_q <= 1'b0;
    else                                        ph_q <= ~ph_q;
  end

  assign tick_o = (mode_i == CPI_TWO) | ph_q;
endmodule

// File: rtl/ext_timer_byte.sv
module ext_timer_byte #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic         full_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (we_i)   q_q <= wdata_i;
    else if (inc_i)  q_q <= q_q + 1'b1;
  end

  assign q_o    = q_q;
  assign full_o = &q_q;
endmodule

// File: rtl/ext_timer.sv
module ext_timer
  import ext_timer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_en_i,
  input  logic              clk_mode_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              tmo_o
);
  cpi_mode_e mode;
  logic      tick;
  logic      lo_full, hi_full;
  logic      lo_carry, hi_inc, ovf;
  logic      tmo_q;

  assign mode = cpi_mode_e'(clk_mode_i);

  ext_timer_tick u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .restart_i (lo_we_i),
    .tick_o    (tick)
  );

  ext_timer_byte #(.W(BYTE_W)) u_lo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (lo_we_i),
    .wdata_i (wdata_i),
    .inc_i   (tick),
    .q_o     (lo_o),
    .full_o  (lo_full)
  );

  // carry only when the low byte really wraps (not replaced by a write)
  assign lo_carry = tick & lo_full & ~lo_we_i;
  assign hi_inc   = hi_en_i & lo_carry;

  ext_timer_byte #(.W(BYTE_W)) u_hi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (hi_we_i),
    .wdata_i (wdata_i),
    .inc_i   (hi_inc),
    .q_o     (hi_o),
    .full_o  (hi_full)
  );

  assign ovf = hi_en_i ? (lo_carry & hi_full & ~hi_we_i) : lo_carry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmo_q <= 1'b0;
    else         tmo_q <= ovf;
  end

  assign tmo_o = tmo_q;
endmodule

// File: rtl/ext_timer_chk.sv
module ext_timer_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hi_en_i,
  input logic              clk_mode_i,
  input logic              lo_we_i,
  input logic              hi_we_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic [BYTE_W-1:0] lo_o,
  input logic [BYTE_W-1:0] hi_o,
  input logic              tmo_o
);
  localparam logic [BYTE_W-1:0] MAX = '1;
  localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_mode_i && !lo_we_i) |=> lo_o == $past(lo_o) + ONE);

  p_hi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_en_i && !hi_we_i) |=> hi_o == $past(hi_o));

  p_ovf_8_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_en_i && !clk_mode_i && !lo_we_i && lo_o == MAX) |=> tmo_o);

  p_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_en_i && !clk_mode_i && !lo_we_i && !hi_we_i && lo_o == MAX)
      |=> hi_o == $past(hi_o) + ONE);

  p_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> !tmo_o);

  p_tmo_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> lo_o == '0);

  p_lo_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> lo_o == $past(wdata_i));

  p_hi_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> hi_o == $past(wdata_i));

  p_lo_cancel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> !tmo_o);

  p_hi_cancel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_en_i && hi_we_i) |=> !tmo_o);
endmodule

bind ext_timer ext_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hi_en_i    (hi_en_i),
  .clk_mode_i (clk_mode_i),
  .lo_we_i    (lo_we_i),
  .hi_we_i    (hi_we_i),
  .wdata_i    (wdata_i),
  .lo_o       (lo_o),
  .hi_o       (hi_o),
  .tmo_o      (tmo_o)
);

// File: tb/ext_timer_tb_top.sv
module ext_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hi_en_i = 1'b0;
  logic       clk_mode_i = 1'b0;
  logic       lo_we_i = 1'b0;
  logic       hi_we_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] lo_o, hi_o;
  logic       tmo_o;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk_i = ~clk_i;

  ext_timer dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hi_en_i    (hi_en_i),
    .clk_mode_i (clk_mode_i),
    .lo_we_i    (lo_we_i),
    .hi_we_i    (hi_we_i),
    .wdata_i    (wdata_i),
    .lo_o       (lo_o),
    .hi_o       (hi_o),
    .tmo_o      (tmo_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at falling edge, apply on one rising edge, return at next falling edge
  task automatic wr(input logic lo, input logic hi, input logic [7:0] d);
    lo_we_i = lo; hi_we_i = hi; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    lo_we_i = 1'b0; hi_we_i = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  task automatic run_to_tmo(output int n, input int limit);
    n = 0;
    while (n < limit) begin
      @(posedge clk_i); @(negedge clk_i);
      n++;
      if (tmo_o) break;
    end
  endtask

  task automatic t_reset();
    chk("R1 lo", lo_o, 0);
    chk("R1 hi", hi_o, 0);
    chk("R1 tmo", tmo_o, 0);
  endtask

  task automatic t_two_clock();
    hi_en_i = 1'b0; clk_mode_i = 1'b0;
    wr(1'b1, 1'b0, 8'h10);
    chk("R7 lo load", lo_o, 8'h10);
    step(5);
    chk("R2 five ticks", lo_o, 8'h15);
  endtask

  task automatic t_eight_bit();
    int n;
    hi_en_i = 1'b0; clk_mode_i = 1'b0;
    wr(1'b0, 1'b1, 8'h33);
    wr(1'b1, 1'b0, 8'hFA);
    run_to_tmo(n, 400);
    chk("R4 ticks to wrap", n, 6);
    chk("R6 lo zero at tmo", lo_o, 0);
    chk("R4 hi untouched", hi_o, 8'h33);
    step(1);
    chk("R6 single pulse", tmo_o, 0);
  endtask

  task automatic t_four_clock();
    int n;
    hi_en_i = 1'b0; clk_mode_i = 1'b1;
    wr(1'b1, 1'b0, 8'hF0);
    step(1);
    chk("R3 no tick first edge", lo_o, 8'hF0);
    step(1);
    chk("R3 tick second edge", lo_o, 8'hF1);
    wr(1'b1, 1'b0, 8'hF0);
    run_to_tmo(n, 600);
    chk("R3 edges to wrap", n, 32);
    clk_mode_i = 1'b0;
  endtask

  task automatic t_sixteen_bit();
    int n;
    hi_en_i = 1'b1; clk_mode_i = 1'b0;
    wr(1'b0, 1'b1, 8'hFE);
    wr(1'b1, 1'b0, 8'hF8);
    step(8);
    chk("R5 carry hi", hi_o, 8'hFF);
    chk("R5 carry lo", lo_o, 0);
    chk("R5 no tmo on low wrap", tmo_o, 0);
    run_to_tmo(n, 1000);
    chk("R5 ticks to wrap", n + 8, 264);
    chk("R5 hi zero", hi_o, 0);
    chk("R6 lo zero", lo_o, 0);
    step(1);
    chk("R6 single pulse 16", tmo_o, 0);
  endtask

  task automatic t_hi_priority();
    hi_en_i = 1'b1; clk_mode_i = 1'b0;
    wr(1'b0, 1'b1, 8'h12);
    wr(1'b1, 1'b0, 8'hFF);
    wr(1'b0, 1'b1, 8'h40);
    chk("R8 write beats carry", hi_o, 8'h40);
    chk("R8 lo wrapped", lo_o, 0);
  endtask

  task automatic t_cancel();
    hi_en_i = 1'b0; clk_mode_i = 1'b0;
    wr(1'b1, 1'b0, 8'hFF);
    wr(1'b1, 1'b0, 8'h80);
    chk("R9 lo write no tmo", tmo_o, 0);
    chk("R9 lo loaded", lo_o, 8'h80);
    hi_en_i = 1'b1;
    wr(1'b0, 1'b1, 8'hFF);
    wr(1'b1, 1'b0, 8'hFF);
    wr(1'b0, 1'b1, 8'h07);
    chk("R9 hi write no tmo", tmo_o, 0);
    chk("R9 hi loaded", hi_o, 8'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_two_clock();
    t_eight_bit();
    t_four_clock();
    t_sixteen_bit();
    t_hi_priority();
    t_cancel();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule